// File: doc/BRIEF.md
# Multi-Channel Event Timer with Comparators

The block is a memory-mapped event timer. A free-running up-counter advances by one every clock while a global run bit is set. Up to eight comparator channels watch it, and each channel signals an event when the counter equals its stored match value. A channel either fires once (one-shot) or, if it is built periodic-capable and software selects periodic operation, adds a stored period to its match value on every hit, so it keeps firing at a fixed interval.

Software drives the block through a plain word-addressed register port with single-cycle writes and reads. Read data comes back one cycle after the request with a valid strobe. The port has no back-pressure: the block takes one write and one read in every cycle. A shared status word holds one latched event bit per level-type channel, and software clears a bit by writing one to it. Each channel exports an interrupt line, a stored 5-bit routing field and its trigger-type bit, so the surrounding interrupt fabric can steer and shape the event.

Periodic channels are loaded with a two-write sequence that software arms with a value-set bit. The first comparator write places the absolute next match point and the second write places the period. The bit then drops by itself.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, global config (word 2), status (word 3) and every channel config read 0, except the read-only periodic-capable flag (bit 4). Every comparator reads all ones and all irq_o and route_o bits are 0.
- R2: The counter (word 4) advances by one on every clock while global config bit 0 (run) is 1, and holds while it is 0. A write to word 4 loads the counter and takes priority over counting.
- R3: Word 0 reads {vendor ID in 31:16, zero in 15:13, NUM_CH-1 in 12:8, revision ID in 7:0}. Word 1 reads the tick period in femtoseconds. Global config bit 1 (legacy flag) is stored and read back and has no other effect.
- R4: A channel matches in the cycle when the running counter equals its comparator (word 10+4c). For a level-type channel (config bit 1 = 1, words 8+4c), status bit c is set at the next clock edge, so with the counter loaded to C and the comparator to C+d, irq_o[c] first reads 1 d+1 clocks after the edge that sets run.
- R5: Writing word 3 clears every status bit written as one. Bits written as zero keep their value.
- R6: A level-type channel's irq_o stays 1 while its status bit is set and its interrupt enable (config bit 2) is 1. Clearing the enable drops the line and leaves the status bit set.
- R7: An edge-type channel (config bit 1 = 0) with the enable set gives a one-clock irq_o pulse per match, in the same cycle a level channel would first assert, and leaves its status bit at 0.
- R8: A periodic channel (config bit 3 = 1) adds its stored period to its comparator in the cycle of each match, so matches follow every period clocks with none lost, even when the period is 1.
- R9: With config bits 3 and 6 (value-set) both set, the first comparator write loads the next match value and the second loads the period. Bit 6 then reads 0. Writing the config word restarts the sequence at the first write.
- R10: Config bit 4 reads 1 only on periodic-capable channels (parameter PER_CAP). On other channels bit 3 cannot be set and reads 0.
- R11: Config bits 13:9 (route) and bit 1 (trigger type) appear on route_o[5c+4:5c] and trig_lvl_o[c]. Word 9+4c reads the ROUTE_CAP mask of usable routes. Bit 8 (32-bit mode) is stored and read back.
- R12: A read request on bus_rd returns the addressed word on bus_rdata with bus_rvalid high in the following cycle. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_o | output | NUM_CH | Per-channel interrupt line |
| route_o | output | 5*NUM_CH | Per-channel stored routing field |
| trig_lvl_o | output | NUM_CH | Per-channel trigger type, 1 = level |

## Verification
One-shot level-type runs use random counter start points and random delays. Each run checks the exact clock of the first assertion, so an off-by-one in the compare or in the status register shows up. The same runs then write zero, drop the enable and write one, which separates a true write-one-to-clear from a plain overwrite and separates masking of the line from clearing of the latched bit. Periodic edge-type runs use random first-match offsets and periods loaded through the value-set sequence, and they check three successive pulse times and the one-clock pulse width. A directed period of 1 exposes any tick lost between back-to-back matches. Directed writes to a channel that is not periodic-capable, and to the routing field, cover the capability-dependent decode.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DATA_W    = 32;
  localparam int ROUTE_W   = 5;
  localparam int MAX_CH    = 8;

  // global word addresses
  localparam int A_CAP     = 0;
  localparam int A_TICK    = 1;
  localparam int A_GCFG    = 2;
  localparam int A_STAT    = 3;
  localparam int A_CNT     = 4;
  // channel window
  localparam int A_CH0     = 8;
  localparam int CH_STRIDE = 4;
  localparam int CH_CFG    = 0;
  localparam int CH_RCAP   = 1;
  localparam int CH_CMP    = 2;

  // channel config bit positions
  localparam int B_LVL     = 1;
  localparam int B_IEN     = 2;
  localparam int B_PER     = 3;
  localparam int B_PCAP    = 4;
  localparam int B_VSET    = 6;
  localparam int B_M32     = 8;
  localparam int B_ROUTE   = 9;

  typedef struct packed {
    logic [ROUTE_W-1:0] route;
    logic               mode32;
    logic               valset;
    logic               per;
    logic               ien;
    logic               lvl;
  } ch_cfg_t;

  function automatic int ch_addr(input int c, input int off);
    return A_CH0 + CH_STRIDE * c + off;
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (run)  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter bit PER_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  count,
  input  logic              cfg_we,
  input  ch_cfg_t           cfg_wdata,
  input  logic              cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic              stat_clr,
  output ch_cfg_t           cfg_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [CNT_W-1:0]  period_q,
  output logic              match,
  output logic              status_q,
  output logic              second_q,
  output logic              irq,
  output logic [DATA_W-1:0] rd_cfg
);
  ch_cfg_t cfg_in;
  logic    pulse_q;

  always_comb begin
    cfg_in     = cfg_wdata;
    cfg_in.per = cfg_wdata.per & PER_OK;
  end

  assign match = run && (count == cmp_q);

  // config, comparator and period; a bus write wins over a periodic advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cmp_q    <= '1;
      period_q <= '0;
      second_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q    <= cfg_in;
        second_q <= 1'b0;
      end
      if (cmp_we) begin
        if (cfg_q.per && cfg_q.valset) begin
          if (!second_q) begin
            cmp_q    <= cmp_wdata;
            second_q <= 1'b1;
          end else begin
            period_q     <= cmp_wdata;
            cfg_q.valset <= 1'b0;
            second_q     <= 1'b0;
          end
        end else begin
          cmp_q <= cmp_wdata;
        end
      end else if (match && cfg_q.per) begin
        cmp_q <= cmp_q + period_q;
      end
    end
  end

  // latched level status, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     status_q <= 1'b0;
    else if (match && cfg_q.lvl)    status_q <= 1'b1;
    else if (stat_clr)              status_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= match && !cfg_q.lvl && cfg_q.ien;
  end

  assign irq = cfg_q.lvl ? (status_q && cfg_q.ien) : pulse_q;

  always_comb begin
    rd_cfg                      = '0;
    rd_cfg[B_LVL]               = cfg_q.lvl;
    rd_cfg[B_IEN]               = cfg_q.ien;
    rd_cfg[B_PER]               = cfg_q.per;
    rd_cfg[B_PCAP]              = PER_OK;
    rd_cfg[B_VSET]              = cfg_q.valset;
    rd_cfg[B_M32]               = cfg_q.mode32;
    rd_cfg[B_ROUTE +: ROUTE_W]  = cfg_q.route;
  end
endmodule

// File: rtl/evt_readmux.sv
module evt_readmux
  import evt_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          CNT_W     = 32,
  parameter int          ADDR_W    = 6,
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  parameter logic [7:0]  REV_ID    = 8'h02,
  parameter logic [31:0] TICK_FS   = 32'd10_000_000,
  parameter logic [31:0] ROUTE_CAP = 32'h00FF_0000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              run,
  input  logic                              legacy,
  input  logic [NUM_CH-1:0]                 status,
  input  logic [CNT_W-1:0]                  count,
  input  logic [NUM_CH-1:0][DATA_W-1:0]     ch_cfg,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      ch_cmp,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              rvalid
);
  localparam logic [DATA_W-1:0] CAP_WORD = {VENDOR_ID, 3'b000, 5'(NUM_CH - 1), REV_ID};

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (addr)
      ADDR_W'(A_CAP):  word = CAP_WORD;
      ADDR_W'(A_TICK): word = TICK_FS;
      ADDR_W'(A_GCFG): word = {30'b0, legacy, run};
      ADDR_W'(A_STAT): word = DATA_W'(status);
      ADDR_W'(A_CNT):  word = DATA_W'(count);
      default:         word = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(ch_addr(c, CH_CFG)))  word = ch_cfg[c];
      if (addr == ADDR_W'(ch_addr(c, CH_RCAP))) word = ROUTE_CAP;
      if (addr == ADDR_W'(ch_addr(c, CH_CMP)))  word = DATA_W'(ch_cmp[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= word;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          CNT_W     = 32,
  parameter int          ADDR_W    = 6,
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  parameter logic [7:0]  REV_ID    = 8'h02,
  parameter logic [31:0] TICK_FS   = 32'd10_000_000,
  parameter logic [31:0] ROUTE_CAP = 32'h00FF_0000,
  parameter logic [7:0]  PER_CAP   = 8'h03
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_rvalid,
  output logic [NUM_CH-1:0]         irq_o,
  output logic [NUM_CH*5-1:0]       route_o,
  output logic [NUM_CH-1:0]         trig_lvl_o
);
  logic             en_q, leg_q;
  logic             cnt_load;
  logic [CNT_W-1:0] count;
  logic             wr_gcfg, wr_stat;
  ch_cfg_t          cfg_in;

  logic [NUM_CH-1:0]               ch_cfg_we, ch_cmp_we, ch_clr;
  logic [NUM_CH-1:0]               ch_match, ch_status, ch_second;
  logic [NUM_CH-1:0]               ch_per, ch_lvl, ch_ien, ch_valset;
  logic [NUM_CH-1:0][CNT_W-1:0]    ch_cmp, ch_period;
  logic [NUM_CH-1:0][DATA_W-1:0]   ch_rd_cfg;
  ch_cfg_t                         ch_cfg [NUM_CH];

  assign wr_gcfg  = bus_wr && (bus_addr == ADDR_W'(A_GCFG));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign cnt_load = bus_wr && (bus_addr == ADDR_W'(A_CNT));

  assign cfg_in = '{route:  bus_wdata[B_ROUTE +: ROUTE_W],
                    mode32: bus_wdata[B_M32],
                    valset: bus_wdata[B_VSET],
                    per:    bus_wdata[B_PER],
                    ien:    bus_wdata[B_IEN],
                    lvl:    bus_wdata[B_LVL]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_gcfg) begin
      en_q  <= bus_wdata[0];
      leg_q <= bus_wdata[1];
    end
  end

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_q),
    .load     (cnt_load),
    .load_val (CNT_W'(bus_wdata)),
    .count    (count)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_cfg_we[c] = bus_wr && (bus_addr == ADDR_W'(ch_addr(c, CH_CFG)));
    assign ch_cmp_we[c] = bus_wr && (bus_addr == ADDR_W'(ch_addr(c, CH_CMP)));
    assign ch_clr[c]    = wr_stat && bus_wdata[c];

    evt_channel #(.CNT_W(CNT_W), .PER_OK(PER_CAP[c])) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (en_q),
      .count     (count),
      .cfg_we    (ch_cfg_we[c]),
      .cfg_wdata (cfg_in),
      .cmp_we    (ch_cmp_we[c]),
      .cmp_wdata (CNT_W'(bus_wdata)),
      .stat_clr  (ch_clr[c]),
      .cfg_q     (ch_cfg[c]),
      .cmp_q     (ch_cmp[c]),
      .period_q  (ch_period[c]),
      .match     (ch_match[c]),
      .status_q  (ch_status[c]),
      .second_q  (ch_second[c]),
      .irq       (irq_o[c]),
      .rd_cfg    (ch_rd_cfg[c])
    );

    assign ch_per[c]    = ch_cfg[c].per;
    assign ch_lvl[c]    = ch_cfg[c].lvl;
    assign ch_ien[c]    = ch_cfg[c].ien;
    assign ch_valset[c] = ch_cfg[c].valset;
    assign route_o[c*ROUTE_W +: ROUTE_W] = ch_cfg[c].route;
    assign trig_lvl_o[c] = ch_cfg[c].lvl;
  end

  evt_readmux #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID),
    .REV_ID(REV_ID), .TICK_FS(TICK_FS), .ROUTE_CAP(ROUTE_CAP)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .run    (en_q),
    .legacy (leg_q),
    .status (ch_status),
    .count  (count),
    .ch_cfg (ch_rd_cfg),
    .ch_cmp (ch_cmp),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           run,
  input logic                           cnt_load,
  input logic [CNT_W-1:0]               count,
  input logic [NUM_CH-1:0]              ch_match,
  input logic [NUM_CH-1:0]              ch_per,
  input logic [NUM_CH-1:0]              ch_lvl,
  input logic [NUM_CH-1:0]              ch_ien,
  input logic [NUM_CH-1:0]              ch_status,
  input logic [NUM_CH-1:0]              ch_clr,
  input logic [NUM_CH-1:0]              ch_valset,
  input logic [NUM_CH-1:0]              ch_second,
  input logic [NUM_CH-1:0]              ch_cmp_we,
  input logic [NUM_CH-1:0][CNT_W-1:0]   ch_cmp,
  input logic [NUM_CH-1:0][CNT_W-1:0]   ch_period,
  input logic [NUM_CH-1:0]              irq_o
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_load |=> count == $past(count + CNT_W'(1)))
    else $error("counter did not advance");

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_load |=> $stable(count))
    else $error("stopped counter moved");

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_match[i] && ch_lvl[i] |=> ch_status[i])
      else $error("level match did not latch status");

    p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_clr[i] && !(ch_match[i] && ch_lvl[i]) |=> !ch_status[i])
      else $error("write-one did not clear status");

    p_edge_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] && !ch_lvl[i] && !$past(ch_lvl[i]) |-> $past(ch_match[i] && ch_ien[i]))
      else $error("edge pulse without enabled match");

    p_periodic_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_match[i] && ch_per[i] && !ch_cmp_we[i] |=> ch_cmp[i] == $past(ch_cmp[i] + ch_period[i]))
      else $error("periodic comparator did not advance");

    p_valset_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cmp_we[i] && ch_per[i] && ch_valset[i] && ch_second[i] |=> !ch_valset[i])
      else $error("value-set bit did not drop");
  end
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (en_q),
  .cnt_load  (cnt_load),
  .count     (count),
  .ch_match  (ch_match),
  .ch_per    (ch_per),
  .ch_lvl    (ch_lvl),
  .ch_ien    (ch_ien),
  .ch_status (ch_status),
  .ch_clr    (ch_clr),
  .ch_valset (ch_valset),
  .ch_second (ch_second),
  .ch_cmp_we (ch_cmp_we),
  .ch_cmp    (ch_cmp),
  .ch_period (ch_period),
  .irq_o     (irq_o)
);

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;
  localparam int NUM_CH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [NUM_CH-1:0] irq_o;
  logic [NUM_CH*5-1:0] route_o;
  logic [NUM_CH-1:0] trig_lvl_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic last_rv;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_timer i_evt_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o), .route_o(route_o),
    .trig_lvl_o(trig_lvl_o)
  );

  function automatic int a_cfg(int c);  return 8 + 4*c;  endfunction
  function automatic int a_rcap(int c); return 9 + 4*c;  endfunction
  function automatic int a_cmp(int c);  return 10 + 4*c; endfunction
  function automatic logic [31:0] exp_cap();
    return {16'h5A17, 3'b000, 5'(NUM_CH-1), 8'h02};
  endfunction
  function automatic int exp_fire(int e, int d, int k, int p);
    return e + d + 1 + k*p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; last_rv = bus_rvalid;
  endtask

  task automatic wait_rise(input int ch, input int lim, output int t);
    t = -1;
    for (int k = 0; k < lim; k++) begin
      if (irq_o[ch]) begin t = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int e, e2, s, t, c0, d, p, ch, hi;
    v = $urandom(32'd9117);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 route", 32'(route_o), 32'h0);
    rd(3, v); chk("R1 status", v, 32'h0);
    rd(4, v); chk("R1 counter", v, 32'h0);
    rd(2, v); chk("R1 gcfg", v, 32'h0);
    rd(a_cmp(0), v); chk("R1 comparator", v, 32'hFFFF_FFFF);
    rd(a_cfg(0), v); chk("R1 cfg ch0", v, 32'h10);

    // R12 read timing
    chk("R12 rvalid", 32'(last_rv), 32'h1);
    @(negedge clk); chk("R12 rvalid drop", 32'(bus_rvalid), 32'h0);
    rd(63, v); chk("R12 unmapped", v, 32'h0);

    // R3 identity words and legacy flag
    rd(0, v); chk("R3 cap", v, exp_cap());
    rd(1, v); chk("R3 tick", v, 32'd10_000_000);
    wr(2, 32'h2);
    rd(2, v); chk("R3 legacy readback", v, 32'h2);
    rd(4, v); chk("R3 legacy no run", v, 32'h0);

    // R2 counting and holding
    wr(4, 32'd1000);
    wr(2, 32'h1); e = cyc;
    rd(4, v); s = cyc;
    chk("R2 counting", v, 32'(1000 + (s - 1 - e)));
    wr(2, 32'h0); e2 = cyc;
    repeat (4) @(negedge clk);
    rd(4, v); chk("R2 hold", v, 32'(1000 + (e2 - e)));

    // R10 periodic capability
    rd(a_cfg(2), v); chk("R10 cap flag ch2", v & 32'h10, 32'h0);
    wr(a_cfg(2), 32'h4C);
    rd(a_cfg(2), v); chk("R10 per not settable", v & 32'h8, 32'h0);
    wr(a_cfg(2), 32'h0);

    // R11 routing outputs
    wr(a_cfg(1), (32'd20 << 9) | 32'h102);
    chk("R11 route out", 32'(route_o[9:5]), 32'd20);
    chk("R11 trig out", 32'(trig_lvl_o[1]), 32'h1);
    rd(a_cfg(1), v); chk("R11 cfg readback", v, (32'd20 << 9) | 32'h112);
    rd(a_rcap(1), v); chk("R11 route cap", v, 32'h00FF_0000);
    wr(a_cfg(1), 32'h0);

    // R8 back-to-back matches with period 1
    wr(2, 0); wr(4, 32'd50);
    wr(a_cfg(0), 32'h4C); wr(a_cmp(0), 32'd53); wr(a_cmp(0), 32'd1);
    wr(2, 1); e = cyc;
    wait_rise(0, 50, t);
    chk("R8 p1 first", 32'(t), 32'(exp_fire(e, 3, 0, 1)));
    hi = 0;
    for (int k = 0; k < 5; k++) begin if (irq_o[0]) hi++; @(negedge clk); end
    chk("R8 p1 no lost tick", 32'(hi), 32'd5);
    wr(2, 0); wr(a_cfg(0), 0);

    // R4 R5 R6 random one-shot level runs
    for (int it = 0; it < 6; it++) begin
      ch = $urandom % NUM_CH; c0 = $urandom % 100000; d = 1 + $urandom % 40;
      wr(2, 0); wr(4, 32'(c0));
      wr(a_cfg(ch), 32'h6); wr(a_cmp(ch), 32'(c0 + d)); wr(3, 32'hFFFF_FFFF);
      wr(2, 1); e = cyc;
      wait_rise(ch, 100, t);
      chk("R4 one-shot time", 32'(t), 32'(exp_fire(e, d, 0, 0)));
      rd(3, v); chk("R4 status set", 32'(v[ch]), 32'h1);
      wr(3, 32'h0);
      rd(3, v); chk("R5 zero write keeps", 32'(v[ch]), 32'h1);
      chk("R6 line held", 32'(irq_o[ch]), 32'h1);
      wr(a_cfg(ch), 32'h2);
      chk("R6 enable off drops line", 32'(irq_o[ch]), 32'h0);
      rd(3, v); chk("R6 status kept", 32'(v[ch]), 32'h1);
      wr(3, 32'(1) << ch);
      rd(3, v); chk("R5 one clears", 32'(v[ch]), 32'h0);
      wr(2, 0); wr(a_cfg(ch), 0);
    end

    // R7 R8 R9 random periodic edge runs
    for (int it = 0; it < 6; it++) begin
      ch = $urandom % 2; c0 = $urandom % 100000;
      d = 1 + $urandom % 30; p = 2 + $urandom % 20;
      wr(2, 0); wr(4, 32'(c0)); wr(3, 32'hFFFF_FFFF);
      wr(a_cfg(ch), 32'h4C); wr(a_cmp(ch), 32'(c0 + d)); wr(a_cmp(ch), 32'(p));
      rd(a_cfg(ch), v); chk("R9 valset dropped", v & 32'h48, 32'h8);
      rd(a_cmp(ch), v); chk("R9 first write is match", v, 32'(c0 + d));
      wr(2, 1); e = cyc;
      for (int k = 0; k < 3; k++) begin
        wait_rise(ch, 200, t);
        chk("R8 periodic time", 32'(t), 32'(exp_fire(e, d, k, p)));
        @(negedge clk);
        chk("R7 one-clock pulse", 32'(irq_o[ch]), 32'h0);
      end
      rd(3, v); chk("R7 no status", 32'(v[ch]), 32'h0);
      wr(2, 0); wr(a_cfg(ch), 0);
    end

    finish_run();
  end
endmodule